// File: doc/BRIEF.md
# Dual-Access Register Field with Per-Bit Hardware Qualifier

This block holds one register field of parameterizable width. Software and on-chip logic can both change it. Software writes arrive as a bus word with one enable per byte lane. On-chip logic has four ways to update the field:

- a set-all strobe;
- a clear-all strobe;
- a counter-style load of a precomputed next value;
- a direct load of an input word.

Every hardware update passes through a per-bit qualifier, which decides which bits that update may touch. Bits the qualifier rejects keep their stored value. A build-time parameter picks how the qualifier vector is read: not at all, as an enable vector, or as a mask vector.

All sources feed one fixed priority chain, so exactly one source acts in a cycle. Software writes sit at the top of the chain and ignore the qualifier. The stored value is driven out on every cycle.

Every pin is a plain level or strobe sampled on the rising clock edge. There is no back-pressure and no handshake: a strobe that is high at an edge takes effect at that edge.

Top module: `mhf_field`

## Requirements
- R1: While `rst_n` is low at a rising edge, `field_q` becomes `RESET_VAL` on that edge, whatever the other inputs are.
- R2: When `sw_wr_en` is 1, each byte lane k with `sw_be[k]`=1 copies `sw_wdata[8k+7:8k]` into the field bits at the same positions (only the positions below `WIDTH`). Bits in lanes whose enable is 0 keep their value, and the qualifier has no effect on software writes.
- R3: While `sw_wr_en` is 1, no hardware strobe changes the field. This holds even when every byte enable is 0, in which case the field is unchanged.
- R4: When `hw_set` is 1 and `sw_wr_en` is 0, every permitted bit becomes 1 and every other bit holds.
- R5: When `hw_clr` is 1 and neither `sw_wr_en` nor `hw_set` is 1, every permitted bit becomes 0 and every other bit holds.
- R6: When `cnt_update` is 1 and no higher source (software write, set, clear) is active, every permitted bit i takes `cnt_next[i]` and every other bit holds.
- R7: When `hw_wr_en` is 1 and no other source is active, every permitted bit i takes `hw_wdata[i]` and every other bit holds.
- R8: The parameter `QUAL_MODE` selects the qualifier reading, with these encodings:
  - 0 (none): all bits are permitted and `hw_qual` is ignored.
  - 1 (enable): bit i is permitted when `hw_qual[i]`=1.
  - 2 (mask): bit i is permitted when `hw_qual[i]`=0.
- R9: With no write or update input active, the field holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wdata | input | BUS_W | Software write data; field bit i maps to bus bit i |
| sw_be | input | BUS_W/8 | Byte-lane enables for the software write |
| hw_set | input | 1 | Set permitted bits to 1 |
| hw_clr | input | 1 | Clear permitted bits to 0 |
| cnt_update | input | 1 | Load `cnt_next` into permitted bits |
| cnt_next | input | WIDTH | Precomputed counter next value |
| hw_wr_en | input | 1 | Load `hw_wdata` into permitted bits |
| hw_wdata | input | WIDTH | Hardware write data |
| hw_qual | input | WIDTH | Per-bit qualifier vector (enable or mask, per `QUAL_MODE`) |
| field_q | output | WIDTH | Stored field value |

## Verification
Three copies of the field, one per qualifier mode, share the same stimulus. The same qualifier pattern therefore has to produce complementary results in enable and mask mode, and has to be ignored in the unqualified copy. Directed steps then drive strobes in pairs to separate each priority level from the one below it. They also cover:

- a software write with all byte enables clear, which must still block hardware;
- a byte lane that lies beyond the field width.

A long run of random strobes, qualifiers and byte enables follows, with occasional resets in the middle of the run, compared against a per-bit behavioural model on every clock.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  typedef enum logic [1:0] {
    QUAL_NONE   = 2'd0,
    QUAL_ENABLE = 2'd1,
    QUAL_MASK   = 2'd2
  } qual_mode_e;

  typedef enum logic [2:0] {
    SRC_IDLE = 3'd0,
    SRC_SW   = 3'd1,
    SRC_SET  = 3'd2,
    SRC_CLR  = 3'd3,
    SRC_CNT  = 3'd4,
    SRC_HWR  = 3'd5
  } src_e;
endpackage

// File: rtl/mhf_qualify.sv
module mhf_qualify #(
  parameter int WIDTH = 12,
  parameter mhf_pkg::qual_mode_e QUAL_MODE = mhf_pkg::QUAL_ENABLE
) (
  input  logic [WIDTH-1:0] hw_qual,
  output logic [WIDTH-1:0] permit
);
  // Mode is resolved at elaboration: each bit is either a wire, an inverter or a constant.
  generate
    if (QUAL_MODE == mhf_pkg::QUAL_NONE) begin : g_none
      logic unused_qual;
      assign unused_qual = ^hw_qual;
      assign permit = '1;
    end else begin : g_bits
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (QUAL_MODE == mhf_pkg::QUAL_MASK) begin : g_mask
          assign permit[i] = ~hw_qual[i];
        end else begin : g_en
          assign permit[i] = hw_qual[i];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/mhf_swlane.sv
module mhf_swlane #(
  parameter int WIDTH = 12,
  parameter int BUS_W = 32,
  localparam int NB = BUS_W / 8
) (
  input  logic [BUS_W-1:0] sw_wdata,
  input  logic [NB-1:0]    sw_be,
  output logic [WIDTH-1:0] lane_bits,
  output logic [WIDTH-1:0] sw_bits
);
  // Each field bit inherits the enable of the byte lane it sits in.
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
      assign lane_bits[i] = sw_be[i / 8];
      assign sw_bits[i]   = sw_wdata[i];
    end
  endgenerate

  // Bus bits and lanes above the field width are not connected to anything.
  logic unused_bus;
  assign unused_bus = ^{sw_wdata, sw_be};
endmodule

// File: rtl/mhf_arbiter.sv
module mhf_arbiter (
  input  logic           sw_wr_en,
  input  logic           hw_set,
  input  logic           hw_clr,
  input  logic           cnt_update,
  input  logic           hw_wr_en,
  output mhf_pkg::src_e  src
);
  // Fixed order: software, set, clear, counter, direct hardware write.
  always_comb begin
    if (sw_wr_en)        src = mhf_pkg::SRC_SW;
    else if (hw_set)     src = mhf_pkg::SRC_SET;
    else if (hw_clr)     src = mhf_pkg::SRC_CLR;
    else if (cnt_update) src = mhf_pkg::SRC_CNT;
    else if (hw_wr_en)   src = mhf_pkg::SRC_HWR;
    else                 src = mhf_pkg::SRC_IDLE;
  end
endmodule

// File: rtl/mhf_field.sv
module mhf_field #(
  parameter int WIDTH = 12,
  parameter int BUS_W = 32,
  parameter logic [WIDTH-1:0] RESET_VAL = 12'h5A3,
  parameter mhf_pkg::qual_mode_e QUAL_MODE = mhf_pkg::QUAL_ENABLE,
  localparam int NB = BUS_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_wr_en,
  input  logic [BUS_W-1:0] sw_wdata,
  input  logic [NB-1:0]    sw_be,
  input  logic             hw_set,
  input  logic             hw_clr,
  input  logic             cnt_update,
  input  logic [WIDTH-1:0] cnt_next,
  input  logic             hw_wr_en,
  input  logic [WIDTH-1:0] hw_wdata,
  input  logic [WIDTH-1:0] hw_qual,
  output logic [WIDTH-1:0] field_q
);
  logic [WIDTH-1:0] permit;
  logic [WIDTH-1:0] lane_bits;
  logic [WIDTH-1:0] sw_bits;
  logic [WIDTH-1:0] field_d;
  mhf_pkg::src_e    src;

  mhf_qualify #(.WIDTH(WIDTH), .QUAL_MODE(QUAL_MODE)) u_qual (
    .hw_qual (hw_qual),
    .permit  (permit)
  );

  mhf_swlane #(.WIDTH(WIDTH), .BUS_W(BUS_W)) u_lane (
    .sw_wdata  (sw_wdata),
    .sw_be     (sw_be),
    .lane_bits (lane_bits),
    .sw_bits   (sw_bits)
  );

  mhf_arbiter u_arb (
    .sw_wr_en   (sw_wr_en),
    .hw_set     (hw_set),
    .hw_clr     (hw_clr),
    .cnt_update (cnt_update),
    .hw_wr_en   (hw_wr_en),
    .src        (src)
  );

  // Next-value mux: software merges by lane, hardware merges by permit.
  always_comb begin
    case (src)
      mhf_pkg::SRC_SW:  field_d = (field_q & ~lane_bits) | (sw_bits & lane_bits);
      mhf_pkg::SRC_SET: field_d = field_q | permit;
      mhf_pkg::SRC_CLR: field_d = field_q & ~permit;
      mhf_pkg::SRC_CNT: field_d = (field_q & ~permit) | (cnt_next & permit);
      mhf_pkg::SRC_HWR: field_d = (field_q & ~permit) | (hw_wdata & permit);
      default:          field_d = field_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) field_q <= RESET_VAL;
    else        field_q <= field_d;
  end

  // A hardware update never moves a bit that the qualifier rejects.
  assert_hw_unpermitted_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr_en && (hw_set || hw_clr || cnt_update || hw_wr_en))
      |=> (((field_q ^ $past(field_q)) & ~$past(permit)) == '0));

  // Software writes leave disabled lanes alone, and block hardware even with no lane enabled.
  assert_sw_lane_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_en |=> (((field_q ^ $past(field_q)) & ~$past(lane_bits)) == '0));

  assert_set_reaches_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set && !sw_wr_en) |=> ((field_q & $past(permit)) == $past(permit)));

  assert_clr_reaches_zeros_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_clr && !hw_set && !sw_wr_en) |=> ((field_q & $past(permit)) == '0));

  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_wr_en || hw_set || hw_clr || cnt_update || hw_wr_en) |=> $stable(field_q));
endmodule

// File: tb/mhf_field_test.sv
module mhf_field_test;
  import mhf_pkg::*;

  localparam int W  = 12;
  localparam int BW = 32;
  localparam int NB = BW / 8;
  localparam logic [W-1:0] RV = 12'h5A3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          sw_wr_en;
  logic [BW-1:0] sw_wdata;
  logic [NB-1:0] sw_be;
  logic          hw_set, hw_clr, cnt_update, hw_wr_en;
  logic [W-1:0]  cnt_next, hw_wdata, hw_qual;
  logic [W-1:0]  q_en, q_mask, q_none;

  mhf_field #(.WIDTH(W), .BUS_W(BW), .RESET_VAL(RV), .QUAL_MODE(QUAL_ENABLE)) uut (
    .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wdata(sw_wdata), .sw_be(sw_be),
    .hw_set(hw_set), .hw_clr(hw_clr), .cnt_update(cnt_update), .cnt_next(cnt_next),
    .hw_wr_en(hw_wr_en), .hw_wdata(hw_wdata), .hw_qual(hw_qual), .field_q(q_en));

  mhf_field #(.WIDTH(W), .BUS_W(BW), .RESET_VAL(RV), .QUAL_MODE(QUAL_MASK)) uut_mask (
    .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wdata(sw_wdata), .sw_be(sw_be),
    .hw_set(hw_set), .hw_clr(hw_clr), .cnt_update(cnt_update), .cnt_next(cnt_next),
    .hw_wr_en(hw_wr_en), .hw_wdata(hw_wdata), .hw_qual(hw_qual), .field_q(q_mask));

  mhf_field #(.WIDTH(W), .BUS_W(BW), .RESET_VAL(RV), .QUAL_MODE(QUAL_NONE)) uut_none (
    .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wdata(sw_wdata), .sw_be(sw_be),
    .hw_set(hw_set), .hw_clr(hw_clr), .cnt_update(cnt_update), .cnt_next(cnt_next),
    .hw_wr_en(hw_wr_en), .hw_wdata(hw_wdata), .hw_qual(hw_qual), .field_q(q_none));

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  logic [W-1:0] exp_en, exp_mask, exp_none;

  // Behavioural model, one bit at a time. mode: 0 none, 1 enable, 2 mask (R8).
  function automatic logic [W-1:0] model(int mode, logic [W-1:0] cur);
    logic [W-1:0] r = cur;
    if (!rst_n) return RV;
    for (int i = 0; i < W; i++) begin
      bit ok;
      ok = (mode == 0) ? 1'b1 : ((mode == 1) ? hw_qual[i] : !hw_qual[i]);
      if (sw_wr_en) begin
        if (sw_be[i / 8]) r[i] = sw_wdata[i];
      end else if (hw_set) begin
        if (ok) r[i] = 1'b1;
      end else if (hw_clr) begin
        if (ok) r[i] = 1'b0;
      end else if (cnt_update) begin
        if (ok) r[i] = cnt_next[i];
      end else if (hw_wr_en) begin
        if (ok) r[i] = hw_wdata[i];
      end
    end
    return r;
  endfunction

  function automatic string tag(int mode);
    bit any_hw;
    any_hw = hw_set | hw_clr | cnt_update | hw_wr_en;
    if (!rst_n) return "R1";
    if (sw_wr_en) return any_hw ? "R3" : "R2";
    if (any_hw && mode == 0) return "R8";
    if (hw_set) return "R4";
    if (hw_clr) return "R5";
    if (cnt_update) return "R6";
    if (hw_wr_en) return "R7";
    return "R9";
  endfunction

  task automatic check(string req, string who, logic [W-1:0] act, logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (%s): got %03h expected %03h", req, who, act, exp);
    end
  endtask

  // Inputs are already set (just after a falling edge); apply one rising edge and compare.
  task automatic step();
    string t_en, t_mask, t_none;
    exp_en = model(1, exp_en);  t_en = tag(1);
    exp_mask = model(2, exp_mask); t_mask = tag(2);
    exp_none = model(0, exp_none); t_none = tag(0);
    @(posedge clk);
    @(negedge clk);
    check(t_en, "enable", q_en, exp_en);
    check(t_mask, "mask", q_mask, exp_mask);
    check(t_none, "none", q_none, exp_none);
  endtask

  task automatic idle_inputs();
    sw_wr_en = 0; sw_wdata = '0; sw_be = '0;
    hw_set = 0; hw_clr = 0; cnt_update = 0; hw_wr_en = 0;
    cnt_next = '0; hw_wdata = '0; hw_qual = '0;
  endtask

  initial begin
    #(20000 * 10);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    exp_en = 'x; exp_mask = 'x; exp_none = 'x;
    @(negedge clk);
    hw_set = 1;                          // R1: reset beats an active strobe
    step();
    step();
    rst_n = 1; idle_inputs();
    step();                              // R9: idle holds reset value

    hw_qual = 12'h0F0; hw_set = 1; step();                         // R4
    idle_inputs(); hw_qual = 12'h00F; hw_clr = 1; step();          // R5
    idle_inputs(); hw_qual = 12'hF0F; cnt_update = 1; cnt_next = 12'hABC; step(); // R6
    idle_inputs(); hw_qual = 12'h3C3; hw_wr_en = 1; hw_wdata = 12'h321; step();   // R7
    idle_inputs(); hw_qual = 12'hFFF; hw_set = 1; hw_clr = 1; step();             // R4 over clear
    idle_inputs(); hw_qual = 12'h555; hw_clr = 1; cnt_update = 1; cnt_next = 12'hFFF; step(); // R5 over counter
    idle_inputs(); hw_qual = 12'hAAA; cnt_update = 1; cnt_next = 12'h0F0;
    hw_wr_en = 1; hw_wdata = 12'hF0F; step();                      // R6 over direct write
    idle_inputs(); sw_wr_en = 1; sw_be = 4'b0001; sw_wdata = '1; hw_clr = 1; hw_qual = 12'h000; step(); // R3
    idle_inputs(); sw_wr_en = 1; sw_be = 4'b0000; sw_wdata = '0; hw_set = 1; step(); // R3 empty lanes
    idle_inputs(); sw_wr_en = 1; sw_be = 4'b0010; sw_wdata = 32'h0000_0000; step();  // R2 upper lane
    idle_inputs(); sw_wr_en = 1; sw_be = 4'b1100; sw_wdata = 32'hFFFF_FFFF; step();  // R2 lanes beyond field
    idle_inputs(); step();                                         // R9

    for (int n = 0; n < 600; n++) begin
      rst_n      = ($urandom_range(0, 49) != 0);
      sw_wr_en   = ($urandom_range(0, 5) == 0);
      sw_wdata   = $urandom;
      sw_be      = NB'($urandom);
      hw_set     = ($urandom_range(0, 5) == 0);
      hw_clr     = ($urandom_range(0, 4) == 0);
      cnt_update = ($urandom_range(0, 2) == 0);
      hw_wr_en   = ($urandom_range(0, 1) == 0);
      cnt_next   = W'($urandom);
      hw_wdata   = W'($urandom);
      hw_qual    = W'($urandom);
      step();
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule